// File: doc/BRIEF.md
# Illegal Opcode Exception Trap Unit

This block examines the 32-bit instruction word that is about to execute and decides whether it carries a reserved encoding. The word is reserved when two conditions both hold. The six bits 10 down to 5 must all be ones. The four-bit field in bits 26 down to 23 must hold a value from 3 to 15. On such a word, while the valid strobe is high, the unit enters the trap in one clock edge. It copies the restart PC and the unmodified status word into their save registers. It puts the fixed cause code 0x0060 into the low half of the cause register. It raises the exception-in-progress and interrupt-disable status bits. It sends the PC to the handler vector 0x00000060.

The unit holds the PC, both save registers, the cause register and the status word. Between traps, the surrounding core loads any of these registers through a single write port. A trap and a write in the same cycle resolve in favour of the trap for every register. The trap-taken output is combinational. It is high during the cycle in which the offending word is presented, before the edge that commits the state.

Top module: `illop_trap`

## Requirements
- R1: A word is reserved when bits [10:5] equal 6'b111111 and bits [26:23] hold a value from 4'd3 to 4'd15 inclusive, whatever the other bits are. With `insn_valid` high on such a word, `trap_taken` is high in that same cycle.
- R2: A word whose bits [26:23] are 0, 1 or 2, or whose bits [10:5] are not all ones, causes no trap. `trap_taken` stays low and no register changes.
- R3: While `insn_valid` is low, even a reserved word causes no trap, and no register changes.
- R4: On a trap edge, `epc_q` takes the value of `restart_pc`.
- R5: On a trap edge, `epsw_q` takes the status word as it was before that edge.
- R6: On a trap edge, `cause_q[15:0]` becomes 16'h0060 and `cause_q[31:16]` keeps its value.
- R7: On a trap edge, status bit 6 (exception in progress) and bit 5 (interrupt disable) are set. Bits 7 and 4..0 keep their values.
- R8: On a trap edge, `pc_q` becomes 32'h00000060.
- R9: After reset, `psw_q` is 32'h00000020, while `pc_q`, `epc_q`, `epsw_q` and `cause_q` are zero.
- R10: `psw_q[31:8]` always reads zero, including after a write of ones to those bits.
- R11: Without a trap, `wr_en` loads `wr_data` into the register named by `wr_sel`: 0 PC, 1 exception PC, 2 exception status, 3 cause, 4 status. Values 5 to 7 change nothing.
- R12: When a trap and a write happen in the same cycle, the trap values win for every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word is about to execute |
| insn_word | input | 32 | Instruction word under test |
| restart_pc | input | 32 | PC at which execution would resume |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write port |
| wr_data | input | 32 | Write data |
| pc_q | output | 32 | Program counter |
| epc_q | output | 32 | Exception PC save register |
| epsw_q | output | 32 | Exception status save register |
| cause_q | output | 32 | Exception cause register |
| psw_q | output | 32 | Status word |
| trap_taken | output | 1 | High in the cycle a trap is accepted |

## Verification
A wrong decode of the reserved pattern shows up on `trap_taken` in the same cycle the word is presented. Any fault in the state update appears on the register outputs one edge later. Examples are a status snapshot taken after modification, a damaged upper cause half, or a write that overrides the trap. The cases to watch most closely are the field boundary between 2 and 3, a single missing one in bits [10:5], and a trap that coincides with a write. A status word that is not cleared in its upper bits is visible at every read.

// File: rtl/illop_trap.sv
module illop_trap #(
  parameter int          XLEN       = 32,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0060,
  parameter logic [15:0] CAUSE_CODE = 16'h0060,
  parameter logic [31:0] PSW_RESET  = 32'h0000_0020,
  parameter int          PSW_BITS   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [31:0]     insn_word,
  input  logic [XLEN-1:0] restart_pc,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] epsw_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] psw_q,
  output logic            trap_taken
);

  localparam int HALF    = XLEN / 2;
  localparam int BIT_ID  = 5;
  localparam int BIT_EP  = 6;
  localparam logic [XLEN-1:0] PSW_MASK = {{(XLEN-PSW_BITS){1'b0}}, {PSW_BITS{1'b1}}};
  localparam logic [XLEN-1:0] TRAP_SET = (XLEN'(1) << BIT_ID) | (XLEN'(1) << BIT_EP);

  logic       sub_all_ones;
  logic       grp_in_range;
  logic [3:0] grp_field;

  assign sub_all_ones = &insn_word[10:5];
  assign grp_field    = insn_word[26:23];
  assign grp_in_range = grp_field >= 4'd3;
  assign trap_taken   = insn_valid & sub_all_ones & grp_in_range;

  logic we_pc, we_epc, we_epsw, we_cause, we_psw;
  assign we_pc    = wr_en && wr_sel == 3'd0;
  assign we_epc   = wr_en && wr_sel == 3'd1;
  assign we_epsw  = wr_en && wr_sel == 3'd2;
  assign we_cause = wr_en && wr_sel == 3'd3;
  assign we_psw   = wr_en && wr_sel == 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      epc_q   <= '0;
      epsw_q  <= '0;
      cause_q <= '0;
      psw_q   <= PSW_RESET & PSW_MASK;
    end else if (trap_taken) begin
      pc_q    <= HANDLER_PC[XLEN-1:0];
      epc_q   <= restart_pc;
      epsw_q  <= psw_q;
      cause_q <= {cause_q[XLEN-1:HALF], CAUSE_CODE[HALF-1:0]};
      psw_q   <= psw_q | TRAP_SET;
    end else begin
      if (we_pc)    pc_q    <= wr_data;
      if (we_epc)   epc_q   <= wr_data;
      if (we_epsw)  epsw_q  <= wr_data;
      if (we_cause) cause_q <= wr_data;
      if (we_psw)   psw_q   <= wr_data & PSW_MASK;
    end
  end

endmodule

// File: rtl/illop_trap_chk.sv
module illop_trap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic [31:0] restart_pc,
  input logic        wr_en,
  input logic [31:0] pc_q,
  input logic [31:0] epc_q,
  input logic [31:0] epsw_q,
  input logic [31:0] cause_q,
  input logic [31:0] psw_q,
  input logic        trap_taken
);

  p_valid_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> insn_valid);

  p_epc_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> epc_q == $past(restart_pc));

  p_status_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> epsw_q == $past(psw_q));

  p_cause_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> cause_q[15:0] == 16'h0060 && cause_q[31:16] == $past(cause_q[31:16]));

  p_status_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> psw_q == ($past(psw_q) | 32'h60));

  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> pc_q == 32'h60);

  p_psw_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    psw_q[31:8] == 24'h0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_taken && !wr_en) |=> $stable(pc_q) && $stable(epc_q) && $stable(epsw_q)
                                && $stable(cause_q) && $stable(psw_q));

endmodule

bind illop_trap illop_trap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .restart_pc(restart_pc),
  .wr_en(wr_en), .pc_q(pc_q), .epc_q(epc_q), .epsw_q(epsw_q),
  .cause_q(cause_q), .psw_q(psw_q), .trap_taken(trap_taken)
);

// File: tb/illop_trap_tb.sv
module illop_trap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic [31:0] restart_pc = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pc_q, epc_q, epsw_q, cause_q, psw_q;
  logic        trap_taken;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  illop_trap u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .restart_pc(restart_pc), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc_q(pc_q), .epc_q(epc_q), .epsw_q(epsw_q), .cause_q(cause_q),
    .psw_q(psw_q), .trap_taken(trap_taken)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [3:0] grp, input logic [5:0] sub,
                                          input logic [31:0] noise);
    logic [31:0] w;
    w = noise;
    w[26:23] = grp;
    w[10:5]  = sub;
    return w;
  endfunction

  // present word for one cycle; check pulse before edge, registers after
  task automatic present(input logic v, input logic [31:0] w, input logic [31:0] rpc);
    @(negedge clk);
    insn_valid = v; insn_word = w; restart_pc = rpc;
    #1;
  endtask

  task automatic idle_after;
    @(negedge clk);
    insn_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 psw", psw_q, 32'h20);
    chk("R9 pc", pc_q, 32'h0);
    chk("R9 epc", epc_q, 32'h0);
    chk("R9 epsw", epsw_q, 32'h0);
    chk("R9 cause", cause_q, 32'h0);
    chk("R9 trap low", {31'b0, trap_taken}, 32'h0);
  endtask

  task automatic t_basic_trap;
    present(1'b1, mk_word(4'd3, 6'h3f, 32'h0), 32'h0000_1234);
    chk("R1 pulse field 3", {31'b0, trap_taken}, 32'h1);
    idle_after();
    chk("R4 epc", epc_q, 32'h0000_1234);
    chk("R5 epsw", epsw_q, 32'h20);
    chk("R6 cause", cause_q, 32'h0000_0060);
    chk("R7 psw", psw_q, 32'h60);
    chk("R8 pc", pc_q, 32'h60);
  endtask

  task automatic t_no_trap_patterns;
    logic [31:0] pc0, ep0, es0, ca0, ps0;
    pc0 = pc_q; ep0 = epc_q; es0 = epsw_q; ca0 = cause_q; ps0 = psw_q;
    for (int g = 0; g < 3; g++) begin
      present(1'b1, mk_word(4'(g), 6'h3f, 32'hFFFF_FFFF), 32'hDEAD_0000);
      chk("R2 field below 3", {31'b0, trap_taken}, 32'h0);
    end
    for (int b = 0; b < 6; b++) begin
      present(1'b1, mk_word(4'd9, 6'h3f ^ (6'h1 << b), 32'h0), 32'hDEAD_0004);
      chk("R2 one sub bit clear", {31'b0, trap_taken}, 32'h0);
    end
    idle_after();
    chk("R2 pc held", pc_q, pc0);
    chk("R2 epc held", epc_q, ep0);
    chk("R2 epsw held", epsw_q, es0);
    chk("R2 cause held", cause_q, ca0);
    chk("R2 psw held", psw_q, ps0);
  endtask

  task automatic t_valid_low;
    logic [31:0] ep0;
    ep0 = epc_q;
    present(1'b0, mk_word(4'd15, 6'h3f, 32'h0), 32'hBEEF_0000);
    chk("R3 no pulse", {31'b0, trap_taken}, 32'h0);
    idle_after();
    chk("R3 epc held", epc_q, ep0);
  endtask

  task automatic t_writes_and_mask;
    write_reg(3'd4, 32'hFFFF_FF9F);
    chk("R10 psw upper zero", psw_q, 32'h0000_009F);
    write_reg(3'd3, 32'hABCD_1234);
    chk("R11 cause write", cause_q, 32'hABCD_1234);
    write_reg(3'd0, 32'h0000_4000);
    chk("R11 pc write", pc_q, 32'h0000_4000);
    write_reg(3'd6, 32'h1111_1111);
    chk("R11 sel 6 no effect pc", pc_q, 32'h0000_4000);
    chk("R11 sel 6 no effect psw", psw_q, 32'h0000_009F);
  endtask

  task automatic t_trap_keeps_upper;
    present(1'b1, mk_word(4'd15, 6'h3f, 32'h5555_5555), 32'h0000_8888);
    chk("R1 pulse field 15 noisy", {31'b0, trap_taken}, 32'h1);
    idle_after();
    chk("R6 upper kept", cause_q, 32'hABCD_0060);
    chk("R5 epsw from written psw", epsw_q, 32'h9F);
    chk("R7 other bits kept", psw_q, 32'hFF);
    chk("R4 epc", epc_q, 32'h0000_8888);
  endtask

  task automatic t_priority;
    write_reg(3'd4, 32'h0000_0001);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h7777_7777;
    insn_valid = 1'b1; insn_word = mk_word(4'd7, 6'h3f, 32'h0); restart_pc = 32'h0000_0ABC;
    #1;
    chk("R12 pulse", {31'b0, trap_taken}, 32'h1);
    idle_after();
    chk("R12 pc trap wins", pc_q, 32'h60);
    chk("R12 psw", psw_q, 32'h61);
    chk("R12 epsw", epsw_q, 32'h01);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_basic_trap();
        t_no_trap_patterns();
        t_valid_low();
        t_writes_and_mask();
        t_trap_keeps_upper();
        t_priority();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule